// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer Bank

A memory-mapped peripheral that holds four independent 32-bit down-counters behind a simple single-cycle register bus. A block-wide run bit gates all channels. Each channel also has its own run bit, a reload register, a live counter, an underflow tally and a one-bit interrupt with status, clear and mask. A channel starts from its reload value when its own run bit goes from 0 to 1. It steps down by one per clock while both run bits are set, and on reaching zero it wraps back to the reload value.

Software never reads the live counter directly. A read of a channel's underflow-tally register also copies the live counter into that channel's sample register. A following read of the sample register then returns a value that is consistent with the tally just read. With a reload of all ones, the bitwise inverse of the sample is a free-running elapsed-cycle count. The read data path is combinational: `bus_rdata` is valid in the same cycle as `bus_sel` with `bus_wr` low. Any side effect of a read happens at the clock edge that ends that cycle.

Top module: `tmr_bank`

## Requirements
- R1: After reset every register reads 0, except the revision register at 0x10, which reads the constant 0x0001_0203. `chan_irq` and `irq_o` are low.
- R2: Address map (byte offsets). Global run register at 0x00, using bit 0 only. Revision at 0x10. Channel i occupies a window based at 0x20 + 0x20*i. Inside the window: 0x00 run (bit 0), 0x04 reload, 0x08 sample, 0x0C underflow tally, 0x10 status (bit 0), 0x14 clear (bit 0), 0x18 mask (bit 0).
- R3: A channel's counter changes only while both the global run bit and its own run bit are set. Otherwise it holds its value.
- R4: A write that sets a channel's run bit from 0 to 1 loads the counter with the reload value at that edge. The counter then drops by one on each following enabled clock.
- R5: On an enabled clock with the counter at 0, the counter takes the reload value, the tally increments, and status bit 0 is set.
- R6: A read of the tally register copies the live counter into the sample register at the end of that read cycle. The sample register keeps that value until the next tally read.
- R7: Writing the clear register with bit 0 = 1 clears status. Writing it with bit 0 = 0 leaves status unchanged. An underflow in the same cycle as a clear leaves status set.
- R8: `chan_irq[i]` is channel i's status AND mask bit 0. `irq_o` is the OR of all four.
- R9: A reload write while a channel runs is stored, but the counter uses it only at the next underflow.
- R10: Reads of unmapped offsets return 0, and writes to them change nothing. The revision, sample, tally and status registers ignore writes. `bus_rdata` is 0 when no read is in progress.
- R11: Each channel counts, samples and raises status independently of the others.
- R12: With a reload of 0xFFFF_FFFF, the inverse of the sample equals the number of enabled clocks since the run bit rose, at the moment of the tally read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| chan_irq | output | 4 | Per-channel interrupt |
| irq_o | output | 1 | OR of all channel interrupts |

## Verification
A counter that skips or repeats a step shows as a wrong sample in the first tally read afterwards. The expected value is the reload minus the number of enabled edges counted from the run-bit edge. A wrong wrap point shows in both the tally and the sample residue after several periods. A status bit that is set or cleared wrongly shows on `chan_irq` and `irq_o` in the cycle after the edge that caused it. A wrong snapshot timing shifts the sample by exactly one count.

// File: rtl/tmr_bank_pkg.sv
// Shared constants and types for the timer bank.
// Assumes a byte-addressed bus with 32-byte channel windows.
package tmr_bank_pkg;

    localparam int WIN_LG  = 5;          // log2 of channel window size
    localparam int REV_OFF = 'h10;       // revision register offset

    typedef enum logic [2:0] {
        RG_NONE,
        RG_RUN,
        RG_RELOAD,
        RG_SAMPLE,
        RG_TALLY,
        RG_STAT,
        RG_CLR,
        RG_MASK
    } chan_reg_e;

    // Maps an in-window offset to a channel register
    function automatic chan_reg_e off_to_reg(input logic [WIN_LG-1:0] off);
        chan_reg_e r;
        case (off)
            5'h00:   r = RG_RUN;
            5'h04:   r = RG_RELOAD;
            5'h08:   r = RG_SAMPLE;
            5'h0C:   r = RG_TALLY;
            5'h10:   r = RG_STAT;
            5'h14:   r = RG_CLR;
            5'h18:   r = RG_MASK;
            default: r = RG_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tmr_decode.sv
// Address decoder: flags the global and revision registers, selects one
// channel window and names the register addressed inside it.
// Assumes channel i sits in window i+1 and N_CH+1 fits the window index.
module tmr_decode #(
    parameter int N_CH   = 4,
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0]           addr,
    output logic                        glb_hit,
    output logic                        rev_hit,
    output logic [N_CH-1:0]             ch_hit,
    output tmr_bank_pkg::chan_reg_e     ch_reg
);
    import tmr_bank_pkg::*;

    localparam int IDX_W = ADDR_W - WIN_LG;

    logic [IDX_W-1:0] win;

    // Split the address into window index and in-window offset
    always_comb begin
        win     = addr[ADDR_W-1:WIN_LG];
        glb_hit = (addr == '0);
        rev_hit = (addr == ADDR_W'(REV_OFF));
        ch_reg  = off_to_reg(addr[WIN_LG-1:0]);
    end

    for (genvar i = 0; i < N_CH; i++) begin : g_hit
        // One window comparator per channel
        assign ch_hit[i] = (win == IDX_W'(i + 1));
    end

endmodule

// File: rtl/tmr_chan.sv
// One timer channel: run bit, reload, down-counter with wrap, underflow
// tally, read-triggered sample latch, status/clear/mask interrupt.
// Assumes wr_en and rd_en are already qualified by this channel's window hit.
module tmr_chan #(
    parameter int W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    glb_run,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  tmr_bank_pkg::chan_reg_e reg_sel,
    input  logic [W-1:0]            wdata,
    output logic [W-1:0]            rdata,
    output logic                    irq
);
    import tmr_bank_pkg::*;

    logic         run_q;
    logic [W-1:0] reload_q;
    logic [W-1:0] cnt_q;
    logic [W-1:0] tally_q;
    logic [W-1:0] sample_q;
    logic         stat_q;
    logic         mask_q;

    logic active;
    logic start;
    logic wrap;
    logic clr_hit;

    // Control terms for this cycle
    always_comb begin
        active  = glb_run && run_q;
        start   = wr_en && (reg_sel == RG_RUN) && wdata[0] && !run_q;
        wrap    = active && (cnt_q == '0);
        clr_hit = wr_en && (reg_sel == RG_CLR) && wdata[0];
    end

    // Software-written configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            reload_q <= '0;
            mask_q   <= 1'b0;
        end else if (wr_en) begin
            if (reg_sel == RG_RUN)    run_q    <= wdata[0];
            if (reg_sel == RG_RELOAD) reload_q <= wdata;
            if (reg_sel == RG_MASK)   mask_q   <= wdata[0];
        end
    end

    // Down-counter: load on run rise, wrap at zero, step while active
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (start)  cnt_q <= reload_q;
        else if (wrap)   cnt_q <= reload_q;
        else if (active) cnt_q <= cnt_q - W'(1);
    end

    // Underflow tally
    always_ff @(posedge clk) begin
        if (!rst_n)    tally_q <= '0;
        else if (wrap) tally_q <= tally_q + W'(1);
    end

    // Sample latch, captured by a tally read
    always_ff @(posedge clk) begin
        if (!rst_n)                                  sample_q <= '0;
        else if (rd_en && (reg_sel == RG_TALLY))     sample_q <= cnt_q;
    end

    // Status: underflow sets, clear write resets, set wins a tie
    always_ff @(posedge clk) begin
        if (!rst_n)       stat_q <= 1'b0;
        else if (wrap)    stat_q <= 1'b1;
        else if (clr_hit) stat_q <= 1'b0;
    end

    // Register read mux
    always_comb begin
        case (reg_sel)
            RG_RUN:    rdata = {{(W-1){1'b0}}, run_q};
            RG_RELOAD: rdata = reload_q;
            RG_SAMPLE: rdata = sample_q;
            RG_TALLY:  rdata = tally_q;
            RG_STAT:   rdata = {{(W-1){1'b0}}, stat_q};
            RG_MASK:   rdata = {{(W-1){1'b0}}, mask_q};
            default:   rdata = '0;
        endcase
    end

    assign irq = stat_q && mask_q;

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !start) |=> $stable(cnt_q)); // R3

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1))); // R4

    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt_q == $past(reload_q) && stat_q
                  && tally_q == $past(tally_q) + W'(1))); // R5

    AST_SAMPLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && reg_sel == RG_TALLY) |=> $stable(sample_q)); // R6

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && !wrap) |=> !stat_q); // R7

endmodule

// File: rtl/tmr_bank.sv
// Timer bank top: global run bit, revision constant, address decode,
// N_CH channel instances, read-data merge and interrupt OR.
// Assumes one-cycle bus accesses with combinational read data.
module tmr_bank #(
    parameter int          N_CH   = 4,
    parameter int          W      = 32,
    parameter int          ADDR_W = 8,
    parameter logic [31:0] REV_ID = 32'h0001_0203
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    output logic [N_CH-1:0]   chan_irq,
    output logic              irq_o
);
    import tmr_bank_pkg::*;

    logic            glb_hit;
    logic            rev_hit;
    logic [N_CH-1:0] ch_hit;
    chan_reg_e       ch_reg;
    logic            glb_run_q;
    logic            rd_cyc;
    logic            wr_cyc;
    logic [W-1:0]    ch_rdata [N_CH];

    assign rd_cyc = bus_sel && !bus_wr;
    assign wr_cyc = bus_sel && bus_wr;

    tmr_decode #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_decode (
        .addr    (bus_addr),
        .glb_hit (glb_hit),
        .rev_hit (rev_hit),
        .ch_hit  (ch_hit),
        .ch_reg  (ch_reg)
    );

    // Block-wide run bit
    always_ff @(posedge clk) begin
        if (!rst_n)                  glb_run_q <= 1'b0;
        else if (wr_cyc && glb_hit)  glb_run_q <= bus_wdata[0];
    end

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        tmr_chan #(.W(W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .glb_run (glb_run_q),
            .wr_en   (wr_cyc && ch_hit[i]),
            .rd_en   (rd_cyc && ch_hit[i]),
            .reg_sel (ch_reg),
            .wdata   (bus_wdata),
            .rdata   (ch_rdata[i]),
            .irq     (chan_irq[i])
        );
    end

    // Merge read data from the addressed source
    always_comb begin
        bus_rdata = '0;
        if (rd_cyc) begin
            if (glb_hit)      bus_rdata = {{(W-1){1'b0}}, glb_run_q};
            else if (rev_hit) bus_rdata = W'(REV_ID);
            for (int i = 0; i < N_CH; i++)
                if (ch_hit[i]) bus_rdata = bus_rdata | ch_rdata[i];
        end
    end

    assign irq_o = |chan_irq;

    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_cyc |-> (bus_rdata == '0)); // R10

    AST_IRQ_ANY: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_irq != '0) |-> irq_o); // R8

endmodule

// File: tb/tmr_bank_bench.sv
`timescale 1ns/1ps
module tmr_bank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  chan_irq;
    logic        irq_o;

    int checks = 0;
    int errors = 0;

    localparam logic [31:0] REV = 32'h0001_0203;

    always #2 clk = ~clk;

    tmr_bank u_tmr_bank (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .chan_irq(chan_irq), .irq_o(irq_o)
    );

    function automatic logic [7:0] ca(input int ch, input int off);
        return 8'(32'h20 + 32'h20 * ch + off);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1 bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1 bus_sel = 1'b0;
    endtask

    task automatic idle(input int k);
        repeat (k) @(posedge clk);
    endtask

    task automatic start_ch(input int ch, input logic [31:0] rl);
        wr(8'h00, 32'h1);
        wr(ca(ch, 4), rl);
        wr(ca(ch, 0), 32'h1);
    endtask

    task automatic t_reset_map();
        logic [31:0] d;
        do_reset();
        rd(8'h00, d);       chk("R1 global reset", d, 0);
        rd(8'h10, d);       chk("R1 revision", d, REV);
        rd(ca(3, 8'h18), d); chk("R1 ch3 mask reset", d, 0);
        rd(ca(2, 4), d);    chk("R1 ch2 reload reset", d, 0);
        @(negedge clk);     chk("R1 irq reset", {chan_irq, irq_o}, 0);
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, d);       chk("R2 global bit0 only", d, 1);
        wr(ca(1, 4), 32'h1234_5678);
        rd(ca(1, 4), d);    chk("R2 ch1 reload offset", d, 32'h1234_5678);
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, d);       chk("R10 unmapped 0x04", d, 0);
        wr(ca(0, 8'h1C), 32'hFFFF_FFFF);
        rd(ca(0, 8'h1C), d); chk("R10 unmapped in window", d, 0);
        wr(8'hA0, 32'hFFFF_FFFF);
        rd(8'hA0, d);       chk("R10 beyond last window", d, 0);
        wr(8'h10, 32'h0);
        rd(8'h10, d);       chk("R10 revision read-only", d, REV);
        wr(ca(0, 8), 32'hDEAD_BEEF);
        rd(ca(0, 8), d);    chk("R10 sample read-only", d, 0);
        @(negedge clk);     chk("R10 rdata idle", bus_rdata, 0);
    endtask

    task automatic t_load_step();
        logic [31:0] d;
        do_reset();
        start_ch(0, 32'd20);
        rd(ca(0, 8'h0C), d); chk("R5 tally none yet", d, 0);
        rd(ca(0, 8), d);     chk("R4 load on run rise", d, 20);
        idle(2);
        rd(ca(0, 8'h0C), d);
        rd(ca(0, 8), d);     chk("R4 step down", d, 16);
        rd(ca(0, 8), d);     chk("R6 sample held", d, 16);
    endtask

    task automatic t_gate();
        logic [31:0] d;
        do_reset();
        wr(ca(0, 4), 32'd100);
        wr(ca(0, 0), 32'h1);
        idle(5);
        rd(ca(0, 8'h0C), d);
        rd(ca(0, 8), d);     chk("R3 hold with global off", d, 100);
        wr(8'h00, 32'h1);
        idle(3);
        rd(ca(0, 8'h0C), d);
        rd(ca(0, 8), d);     chk("R3 counts with both on", d, 97);
        wr(ca(0, 0), 32'h0);
        idle(4);
        rd(ca(0, 8'h0C), d);
        rd(ca(0, 8), d);     chk("R3 hold with local off", d, 94);
    endtask

    task automatic t_wrap_irq();
        logic [31:0] d;
        do_reset();
        wr(ca(0, 8'h18), 32'h1);
        start_ch(0, 32'd3);
        idle(10);
        rd(ca(0, 8'h0C), d); chk("R5 tally after wraps", d, 2);
        rd(ca(0, 8), d);     chk("R5 wrap residue", d, 1);
        wr(ca(0, 0), 32'h0);
        rd(ca(0, 8'h10), d); chk("R5 status set", d, 1);
        @(negedge clk);      chk("R8 irq raised", {chan_irq, irq_o}, 5'b0001_1);
        wr(ca(0, 8'h18), 32'h0);
        @(negedge clk);      chk("R8 masked irq", {chan_irq, irq_o}, 0);
        wr(ca(0, 8'h14), 32'h0);
        rd(ca(0, 8'h10), d); chk("R7 clear with 0 ignored", d, 1);
        wr(ca(0, 8'h14), 32'h1);
        rd(ca(0, 8'h10), d); chk("R7 clear", d, 0);
        wr(ca(0, 8'h18), 32'h1);
        @(negedge clk);      chk("R8 irq after clear", {chan_irq, irq_o}, 0);
    endtask

    task automatic t_clear_race();
        logic [31:0] d;
        do_reset();
        start_ch(1, 32'd0);
        idle(2);
        wr(ca(1, 8'h14), 32'h1);
        rd(ca(1, 8'h10), d); chk("R7 underflow beats clear", d, 1);
    endtask

    task automatic t_reload_live();
        logic [31:0] d;
        do_reset();
        start_ch(0, 32'd3);
        wr(ca(0, 4), 32'd7);
        idle(5);
        rd(ca(0, 8'h0C), d); chk("R9 one wrap", d, 1);
        rd(ca(0, 8), d);     chk("R9 new reload at wrap", d, 5);
    endtask

    task automatic t_independent();
        logic [31:0] d;
        do_reset();
        start_ch(2, 32'h10);
        idle(3);
        rd(ca(2, 8'h0C), d);
        rd(ca(2, 8), d);     chk("R11 ch2 counts", d, 32'h0D);
        rd(ca(1, 8'h0C), d); chk("R11 ch1 tally idle", d, 0);
        rd(ca(1, 8), d);     chk("R11 ch1 sample idle", d, 0);
        rd(ca(0, 8), d);     chk("R11 ch0 sample idle", d, 0);
    endtask

    task automatic t_elapsed();
        logic [31:0] d;
        logic [31:0] first;
        do_reset();
        start_ch(3, 32'hFFFF_FFFF);
        idle(5);
        rd(ca(3, 8'h0C), d);
        rd(ca(3, 8), d);     first = ~d;
        chk("R12 elapsed first", first, 5);
        idle(9);
        rd(ca(3, 8'h0C), d);
        rd(ca(3, 8), d);     chk("R12 elapsed second", ~d, 16);
        chk("R12 monotonic", 32'(~d > first), 1);
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset_map();
        t_load_step();
        t_gate();
        t_wrap_irq();
        t_clear_race();
        t_reload_live();
        t_independent();
        t_elapsed();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule